// File: doc/BRIEF.md
# First-Failure Memory Test Log

This block sits beside the result comparator of a memory self-test engine. While a test runs, every compare-valid cycle presents an address, the expected word, the word read back and the data seed of the current pattern. The first compare that mismatches is frozen into a 79-bit record. The record holds the failing address, a per-bit mask of the failing data bits and the seed. Later failures leave the record untouched. A sticky fail flag tells the tester that something went wrong.

At the end of the test, the tester raises the data-shift input, and the record leaves on a single serial pin, least-significant bit first. In bitmap mode the test keeps running during an unload: raising data-shift stalls the pattern engine and drops the fail flag. After a complete unload the record is released, so the next failure can be logged. One instance serves one memory. Several instances side by side give one serial pin per processor memory.

Top module: `failLogTop`

## Requirements
- R1: Asynchronous reset (rstN low) clears logValid, failFlag and serialOut, and empties the record, so that an unload straight after reset delivers 79 zero bits.
- R2: When a compare-valid cycle meets runEn high, no stall, expData different from rdData, no record held and no unload in progress (data-shift low in that cycle and in the two cycles before), logValid rises at that edge. The record becomes {cmpAddr in bits 78:68, expData XOR rdData in bits 67:4, seed in bits 3:0}.
- R3: A compare with expData equal to rdData is not a failure. It leaves logValid and failFlag low.
- R4: While logValid is high, further failing compares do not change the record.
- R5: If data-shift is sampled high at rising edges k, k+1, ..., then bit i of the record appears on serialOut after edge k+1+i. serialOut is low whenever data-shift was low at the two previous edges.
- R6: failFlag rises at the edge after any failing compare accepted while running (not only the first). It clears at the first edge where runEn is low.
- R7: In bitmap mode (bitmapMode high), data-shift high drives stall high at once and clears failFlag at the next edge. A compare made while stalled is ignored and does not create a record.
- R8: In bitmap mode, once all 79 bits have been shifted and data-shift has fallen, logValid clears so that a new first failure can be logged. Outside bitmap mode, logValid stays high after an unload until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Test running |
| bitmapMode | input | 1 | Unload-during-test mode select |
| cmpValid | input | 1 | Compare data valid this cycle |
| cmpAddr | input | 11 | Address of the compared word |
| expData | input | 64 | Expected data |
| rdData | input | 64 | Data read from memory |
| seed | input | 4 | Data seed of the running pattern |
| dataShift | input | 1 | Serial unload enable |
| serialOut | output | 1 | Serial record output, LSB first |
| failFlag | output | 1 | Sticky fail indication |
| logValid | output | 1 | A failure record is held |
| stall | output | 1 | Pause request to the pattern engine |

## Verification
The properties assume that the tester keeps data-shift high for whole unloads and that no compare arrives in the two cycles after data-shift falls. The bench drives compares only between unloads, or deliberately during a bitmap stall. They also assume that bitmapMode does not toggle during an unload. The bench sets the mode right after reset and holds it. Every stimulus change happens on the falling edge, so all inputs are stable around each rising edge.

// File: rtl/failLogPkg.sv
package failLogPkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic captureEn;  // load a fresh record
    logic shiftEn;    // move the record one place toward bit 0
  } logStrobe_t;
endpackage

// File: rtl/failLogPath.sv
module failLogPath
  import failLogPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 64,
  parameter int SEED_W = 4,
  parameter int LOG_W  = ADDR_W + DATA_W + SEED_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobe_t        strb,
  input  logic [ADDR_W-1:0] cmpAddr,
  input  logic [DATA_W-1:0] expData,
  input  logic [DATA_W-1:0] rdData,
  input  logic [SEED_W-1:0] seed,
  output logic              mismatchAny,
  output logic              serialBit,
  output logic [LOG_W-1:0]  logVec
);
  logic [DATA_W-1:0] failMask;
  logic [LOG_W-1:0]  logReg;

  // one mismatch detector per data lane
  for (genvar g = 0; g < DATA_W; g++) begin : gLane
    assign failMask[g] = expData[g] ^ rdData[g];
  end

  assign mismatchAny = |failMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logReg <= '0;
    end else if (strb.captureEn) begin
      logReg <= {cmpAddr, failMask, seed};
    end else if (strb.shiftEn) begin
      logReg <= {1'b0, logReg[LOG_W-1:1]};
    end
  end

  assign serialBit = strb.shiftEn ? logReg[0] : 1'b0;
  assign logVec    = logReg;
endmodule

// File: rtl/failLogCtrl.sv
module failLogCtrl
  import failLogPkg::*;
#(
  parameter int LOG_W = 79
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       bitmapMode,
  input  logic       cmpValid,
  input  logic       dataShift,
  input  logic       mismatchAny,
  output logStrobe_t strb,
  output logic       stall,
  output logic       failFlag,
  output logic       logValid
);
  localparam int CNT_W = $clog2(LOG_W + 1);

  logic             dsD1;
  logic             dsD2;
  logic [CNT_W-1:0] bitCnt;
  logic             busy;
  logic             failHit;
  logic             unloadEnd;
  logic             clearLog;

  assign stall     = bitmapMode & dataShift;
  assign busy      = dataShift | dsD1 | dsD2;
  assign failHit   = cmpValid & runEn & ~stall & mismatchAny;
  assign unloadEnd = dsD2 & ~dsD1 & (bitCnt >= CNT_W'(LOG_W));
  assign clearLog  = bitmapMode & unloadEnd;

  always_comb begin
    strb           = '0;
    strb.captureEn = failHit & ~logValid & ~busy;
    strb.shiftEn   = dsD2;
  end

  // two-stage delay of the unload request gives the fixed output latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dsD1 <= 1'b0;
      dsD2 <= 1'b0;
    end else begin
      dsD1 <= dataShift;
      dsD2 <= dsD1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (dataShift && !dsD1) begin
      bitCnt <= '0;
    end else if (dsD2 && (bitCnt < CNT_W'(LOG_W))) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logValid <= 1'b0;
    end else if (strb.captureEn) begin
      logValid <= 1'b1;
    end else if (clearLog) begin
      logValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failFlag <= 1'b0;
    end else if (!runEn || stall) begin
      failFlag <= 1'b0;
    end else if (failHit) begin
      failFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/failLogTop.sv
module failLogTop
  import failLogPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 64,
  parameter int SEED_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              bitmapMode,
  input  logic              cmpValid,
  input  logic [ADDR_W-1:0] cmpAddr,
  input  logic [DATA_W-1:0] expData,
  input  logic [DATA_W-1:0] rdData,
  input  logic [SEED_W-1:0] seed,
  input  logic              dataShift,
  output logic              serialOut,
  output logic              failFlag,
  output logic              logValid,
  output logic              stall
);
  localparam int LOG_W = ADDR_W + DATA_W + SEED_W;

  logStrobe_t       strb;
  logic             mismatchAny;
  logic [LOG_W-1:0] logVec;

  failLogCtrl #(.LOG_W(LOG_W)) ctrlI (
    .clk(clk), .rstN(rstN), .runEn(runEn), .bitmapMode(bitmapMode),
    .cmpValid(cmpValid), .dataShift(dataShift), .mismatchAny(mismatchAny),
    .strb(strb), .stall(stall), .failFlag(failFlag), .logValid(logValid)
  );

  failLogPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED_W(SEED_W), .LOG_W(LOG_W)) pathI (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpAddr(cmpAddr),
    .expData(expData), .rdData(rdData), .seed(seed),
    .mismatchAny(mismatchAny), .serialBit(serialOut), .logVec(logVec)
  );
endmodule

// File: rtl/failLogChecker.sv
module failLogChecker
  import failLogPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LOG_W  = 79
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic              bitmapMode,
  input logic              cmpValid,
  input logic [DATA_W-1:0] expData,
  input logic [DATA_W-1:0] rdData,
  input logic              dataShift,
  input logic              serialOut,
  input logic              failFlag,
  input logic              logValid,
  input logic              stall,
  input logStrobe_t        strb,
  input logic [LOG_W-1:0]  logVec
);
  // R2: an accepted first failure sets logValid
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!logValid && cmpValid && runEn && !stall && (expData != rdData) &&
     !dataShift && !$past(dataShift) && !$past(dataShift, 2)) |=> logValid);

  // R4: a held record is frozen except while it is being shifted
  assert_log_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (logValid && !strb.shiftEn) |=> $stable(logVec));

  // R5: no serial activity without a recent unload request
  assert_out_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!dataShift && !$past(dataShift)) |=> !serialOut);

  // R6: leaving run drops the fail flag
  assert_flag_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !failFlag);

  // R7: a bitmap unload clears the fail flag
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bitmapMode && dataShift) |=> !failFlag);

  // R7: compares during a stall create no record
  assert_stall_nocap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bitmapMode && dataShift && !logValid) |=> !logValid);
endmodule

bind failLogTop failLogChecker #(.DATA_W(DATA_W), .LOG_W(LOG_W)) chkI (
  .clk(clk), .rstN(rstN), .runEn(runEn), .bitmapMode(bitmapMode),
  .cmpValid(cmpValid), .expData(expData), .rdData(rdData),
  .dataShift(dataShift), .serialOut(serialOut), .failFlag(failFlag),
  .logValid(logValid), .stall(stall), .strb(strb), .logVec(logVec)
);

// File: tb/failLogTop_tb_top.sv
`timescale 1ns/1ps
module failLogTop_tb_top;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 64;
  localparam int SEED_W = 4;
  localparam int LOG_W  = ADDR_W + DATA_W + SEED_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              runEn = 1'b0;
  logic              bitmapMode = 1'b0;
  logic              cmpValid = 1'b0;
  logic [ADDR_W-1:0] cmpAddr = '0;
  logic [DATA_W-1:0] expData = '0;
  logic [DATA_W-1:0] rdData = '0;
  logic [SEED_W-1:0] seed = '0;
  logic              dataShift = 1'b0;
  logic              serialOut;
  logic              failFlag;
  logic              logValid;
  logic              stall;

  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic expQ[$];
  logic mDs1 = 1'b0;
  logic mDs2 = 1'b0;
  logic [LOG_W-1:0] rec1;
  logic [LOG_W-1:0] rec2;
  logic [LOG_W-1:0] rec3;

  always #5 clk = ~clk;

  failLogTop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED_W(SEED_W)) dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .bitmapMode(bitmapMode),
    .cmpValid(cmpValid), .cmpAddr(cmpAddr), .expData(expData), .rdData(rdData),
    .seed(seed), .dataShift(dataShift), .serialOut(serialOut),
    .failFlag(failFlag), .logValid(logValid), .stall(stall)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: models the two-edge output latency from the requirement
  always @(posedge clk) begin
    mDs1 <= dataShift;
    mDs2 <= mDs1;
  end

  always @(negedge clk) begin
    if (mDs2 && expQ.size() > 0) begin
      logic e;
      e = expQ.pop_front();
      check("R5 serial bit", int'(serialOut), int'(e));
    end
  end

  task automatic compare(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                         input logic [DATA_W-1:0] r, input logic [SEED_W-1:0] s);
    cmpAddr = a; expData = e; rdData = r; seed = s; cmpValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmpValid = 1'b0;
  endtask

  // driver: queues the expected record bits, then runs one full unload
  task automatic unload(input logic [LOG_W-1:0] rec);
    for (int i = 0; i < LOG_W; i++) expQ.push_back(rec[i]);
    dataShift = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (bitmapMode) begin
      check("R7 stall during unload", int'(stall), 1);
      check("R7 flag cleared by unload", int'(failFlag), 0);
    end
    repeat (LOG_W) @(posedge clk);
    @(negedge clk);
    dataShift = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R5 all bits consumed", expQ.size(), 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 logValid", int'(logValid), 0);
    check("R1 failFlag", int'(failFlag), 0);
    check("R1 serialOut", int'(serialOut), 0);
    check("R1 stall", int'(stall), 0);
    rstN = 1'b1;

    // normal mode: first failure only
    runEn = 1'b1;
    compare(11'h005, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0F0F_0F0F_0F0F_0F0F, 4'h2);
    check("R3 passing compare logValid", int'(logValid), 0);
    check("R3 passing compare failFlag", int'(failFlag), 0);
    compare(11'h2A5, 64'hFFFF_0000_1234_5678, 64'hFFFF_0001_1234_567C, 4'h9);
    rec1 = {11'h2A5, 64'h0000_0001_0000_0004, 4'h9};
    check("R2 logValid set", int'(logValid), 1);
    check("R6 failFlag set", int'(failFlag), 1);
    compare(11'h011, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h6);
    check("R4 logValid kept", int'(logValid), 1);
    check("R6 failFlag still set", int'(failFlag), 1);
    runEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 failFlag cleared by run low", int'(failFlag), 0);
    unload(rec1);
    check("R8 normal mode keeps logValid", int'(logValid), 1);

    // reset empties the record
    doReset();
    check("R1 logValid after reset", int'(logValid), 0);
    unload('0);

    // bitmap mode
    bitmapMode = 1'b1;
    runEn = 1'b1;
    dataShift = 1'b1;
    #1;
    check("R7 stall immediate", int'(stall), 1);
    @(negedge clk);
    compare(11'h3C3, 64'h1, 64'h2, 4'h1);
    check("R7 stalled compare ignored", int'(logValid), 0);
    check("R7 stalled compare no flag", int'(failFlag), 0);
    dataShift = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 stall released", int'(stall), 0);
    compare(11'h7FF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'hF);
    rec2 = {11'h7FF, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF};
    check("R2 bitmap capture", int'(logValid), 1);
    check("R6 bitmap failFlag", int'(failFlag), 1);
    unload(rec2);
    check("R8 bitmap logValid released", int'(logValid), 0);
    compare(11'h123, 64'hA5A5_A5A5_A5A5_A5A5, 64'h5A5A_A5A5_A5A5_A5A4, 4'h3);
    rec3 = {11'h123, 64'hFFFF_0000_0000_0001, 4'h3};
    check("R8 next failure captured", int'(logValid), 1);
    unload(rec3);
    check("R8 logValid released again", int'(logValid), 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule